// File: doc/BRIEF.md
# Serial NRZI Decoder and Self-Synchronizing Descrambler

This block sits behind a clock-recovery stage and takes the recovered serial line one bit at a time, each bit marked by a strobe from the serial-clock domain. It undoes the two line codings applied at the transmitter. First it turns the transition-coded (NRZI) stream back into level-coded (NRZ) bits. Then it multiplies that stream, modulo 2, by x^9 + x^4 + 1. Taken together, the two steps are multiplication of the received stream by (x^9 + x^4 + 1)(x + 1). Written out, this is x^10 + x^9 + x^5 + x^4 + x + 1.

All taps come from bits already received, so the descrambler needs no seed. It locks to any transmitter state on its own once ten received bits have passed through its delay line. A parameter selects between two structures. The fused form keeps one 10-stage chain of received bits and applies the expanded polynomial. The cascade form forms the NRZ differences first and then applies the 9th-order taps. Both give the same result bit for bit. Word alignment, clock recovery and input selection are handled elsewhere.

Top module: `serial_nrzi_descrambler`

## Requirements
- R1: An active-high synchronous `rst` clears the delay line, the fill count, `dec_bit` and `dec_valid` to 0 at the next rising edge. When `rst` and `rx_strobe` are both high in the same cycle, reset wins and the strobed bit is discarded.
- R2: The NRZI stage yields 1 when an accepted received bit differs from the previously accepted received bit, and 0 when the two are equal. A received level held constant therefore decodes to an all-zero NRZ stream.
- R3: For accepted received bits r[n], the decoded bit is r[n]^r[n-1]^r[n-4]^r[n-5]^r[n-9]^r[n-10]. Delay-line positions not yet written since reset count as 0.
- R4: A strobe at a rising edge updates `dec_bit` at that same edge, so the result is visible one clock after the strobe. `dec_valid` is high only in the cycle that follows a strobe.
- R5: In a cycle with `rx_strobe` low, the delay line does not advance. At the next edge `dec_bit` keeps its previous value and `dec_valid` goes low.
- R6: After reset, the first 10 accepted bits give `dec_valid` = 0, although `dec_bit` is still updated. Every accepted bit from the 11th onward gives `dec_valid` = 1.
- R7: A stream built by dividing data by x^9 + x^4 + 1 and then NRZI-encoding it, from any transmitter state, is recovered exactly. This holds for every accepted bit from the 11th bit the transmitter has produced since that state.
- R8: The fused (`SDD_FUSED`) and cascade (`SDD_CASCADE`) structures produce identical `dec_bit` and `dec_valid` for the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Received NRZI line bit |
| rx_strobe | input | 1 | Marks `rx_bit` as a new line bit in this cycle |
| dec_bit | output | 1 | Decoded, descrambled data bit |
| dec_valid | output | 1 | `dec_bit` is a fresh result computed from a full delay line |

## Verification
Two events can land on the same clock edge. The first pair is the end of the fill phase and the emission of a result: the 11th strobe must both complete the fill and raise `dec_valid`. Strobes are spaced by idle cycles around that point so that an off-by-one in the fill count shows up as a misplaced valid. The second pair is reset and an accepted bit arriving together. The bench raises `rst` and `rx_strobe` in one cycle and then sends ten more strobes; it expects `dec_valid` to stay low for all ten, which shows that the strobed bit neither shifted the delay line nor counted toward the fill.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   typedef enum logic {
      SDD_FUSED   = 1'b0,
      SDD_CASCADE = 1'b1
   } sdd_variant_e;

   localparam int SDD_MASK_W = 32;

   // Tap mask of (x^order + x^mid + 1), times (x + 1) when nrzi is set.
   // Bit k selects the received bit that is k positions old.
   function automatic logic [SDD_MASK_W-1:0] sdd_tap_mask(input int order,
                                                          input int mid,
                                                          input bit nrzi);
      logic [SDD_MASK_W-1:0] p;
      p        = '0;
      p[0]     = 1'b1;
      p[mid]   = 1'b1;
      p[order] = 1'b1;
      if (nrzi) p = p ^ (p << 1);
      return p;
   endfunction

endpackage

// File: rtl/sdd_history.sv
module sdd_history #(
   parameter int DEPTH = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_stage
         logic src;
         logic stage_q;
         if (k == 0) begin : g_head
            assign src = din;
         end else begin : g_body
            assign src = taps[k-1];
         end
         always_ff @(posedge clk) begin
            if (rst)           stage_q <= 1'b0;
            else if (shift_en) stage_q <= src;
         end
         assign taps[k] = stage_q;
      end
   endgenerate

   AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> taps[DEPTH-1] == $past(taps[DEPTH-2])) else $error("shift"); // R3

   AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(taps)) else $error("idle shift"); // R5

endmodule

// File: rtl/sdd_fill_tracker.sv
module sdd_fill_tracker #(
   parameter int FILL = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic primed
);

   localparam int CW = $clog2(FILL + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                 cnt <= '0;
      else if (tick && !primed) cnt <= cnt + CW'(1);
   end

   assign primed = (cnt == CW'(FILL));

   AST_FILL_NO_DROP: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cnt >= $past(cnt)) else $error("fill dropped"); // R6

   AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (rst)
      primed |=> primed) else $error("primed lost"); // R6

endmodule

// File: rtl/sdd_tap_combiner.sv
module sdd_tap_combiner
   import sdd_pkg::*;
#(
   parameter int           ORDER   = 9,
   parameter int           MID     = 4,
   parameter bit           NRZI_EN = 1'b1,
   parameter sdd_variant_e VARIANT = SDD_FUSED,
   parameter int           DEPTH   = ORDER + (NRZI_EN ? 1 : 0)
) (
   input  logic             cur,
   input  logic [DEPTH-1:0] hist,
   output logic             y
);

   localparam int WIN = DEPTH + 1;

   logic [WIN-1:0] window;
   assign window = {hist, cur};

   generate
      if (VARIANT == SDD_FUSED) begin : g_fused
         localparam logic [SDD_MASK_W-1:0] MASK = sdd_tap_mask(ORDER, MID, NRZI_EN);
         assign y = ^(window & MASK[WIN-1:0]);
      end else begin : g_cascade
         logic [ORDER:0] nrz;
         for (genvar k = 0; k <= ORDER; k++) begin : g_nrz
            if (NRZI_EN) begin : g_diff
               assign nrz[k] = window[k] ^ window[k+1];
            end else begin : g_pass
               assign nrz[k] = window[k];
            end
         end
         assign y = nrz[0] ^ nrz[MID] ^ nrz[ORDER];
      end
   endgenerate

endmodule

// File: rtl/serial_nrzi_descrambler.sv
module serial_nrzi_descrambler
   import sdd_pkg::*;
#(
   parameter int           ORDER   = 9,
   parameter int           MID     = 4,
   parameter bit           NRZI_EN = 1'b1,
   parameter sdd_variant_e VARIANT = SDD_FUSED
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_bit,
   input  logic rx_strobe,
   output logic dec_bit,
   output logic dec_valid
);

   localparam int DEPTH = ORDER + (NRZI_EN ? 1 : 0);

   generate
      if (ORDER < 2 || ORDER + 2 > SDD_MASK_W) begin : g_bad_order
         $error("ORDER out of range");
      end
      if (MID < 1 || MID >= ORDER) begin : g_bad_mid
         $error("MID must lie strictly between 0 and ORDER");
      end
   endgenerate

   logic [DEPTH-1:0] hist;
   logic             primed;
   logic             y;

   sdd_history #(.DEPTH(DEPTH)) u_history (
      .clk      (clk),
      .rst      (rst),
      .shift_en (rx_strobe),
      .din      (rx_bit),
      .taps     (hist)
   );

   sdd_fill_tracker #(.FILL(DEPTH)) u_fill (
      .clk    (clk),
      .rst    (rst),
      .tick   (rx_strobe),
      .primed (primed)
   );

   sdd_tap_combiner #(
      .ORDER   (ORDER),
      .MID     (MID),
      .NRZI_EN (NRZI_EN),
      .VARIANT (VARIANT),
      .DEPTH   (DEPTH)
   ) u_comb (
      .cur  (rx_bit),
      .hist (hist),
      .y    (y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dec_bit   <= 1'b0;
         dec_valid <= 1'b0;
      end else begin
         dec_valid <= rx_strobe & primed;
         if (rx_strobe) dec_bit <= y;
      end
   end

   AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      dec_valid |-> $past(rx_strobe)) else $error("valid w/o strobe"); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rx_strobe |=> (!dec_valid && $stable(dec_bit))) else $error("idle change"); // R5

   AST_VALID_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
      dec_valid |-> $past(primed)) else $error("valid before fill"); // R6

   AST_FILLED_STROBE_VALID: assert property (@(posedge clk) disable iff (rst)
      (rx_strobe && primed) |=> dec_valid) else $error("missing valid"); // R6

endmodule

// File: tb/test_serial_nrzi_descrambler.sv
`timescale 1ns/1ps
module test_serial_nrzi_descrambler;
   import sdd_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rx_bit = 1'b0;
   logic rx_strobe = 1'b0;
   logic dec_bit, dec_valid, alt_bit, alt_valid;

   always #2.5 clk = ~clk;

   serial_nrzi_descrambler i_serial_nrzi_descrambler (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
      .dec_bit(dec_bit), .dec_valid(dec_valid));

   serial_nrzi_descrambler #(.VARIANT(SDD_CASCADE)) i_serial_nrzi_descrambler_cascade (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
      .dec_bit(alt_bit), .dec_valid(alt_valid));

   typedef struct {
      bit    vld;
      bit    b;
      bit    chk;
      bit    data;
      string tag_v;
      string tag_b;
   } exp_t;

   exp_t q[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   done = 1'b0;

   // reference model: previous received bits, fill count, last output
   bit m_h[1:10];
   int m_fill = 0;
   bit m_last = 1'b0;
   // transmitter model
   bit e_s[1:9];
   bit e_t = 1'b0;
   int e_cnt = 0;
   string bit_tag = "R3";

   task automatic check(string req, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step(bit strobe, bit b, bit rst_in, bit has_data, bit data);
      exp_t e;
      bit y;
      @(negedge clk);
      rst = rst_in;
      rx_strobe = strobe;
      rx_bit = b;
      e.chk = 1'b0;
      e.data = data;
      if (rst_in) begin
         for (int k = 1; k <= 10; k++) m_h[k] = 1'b0;
         m_fill = 0;
         m_last = 1'b0;
         e.vld = 1'b0;
         e.tag_v = "R1";
         e.tag_b = "R1";
      end else if (strobe) begin
         y = b ^ m_h[1] ^ m_h[4] ^ m_h[5] ^ m_h[9] ^ m_h[10];
         e.vld = (m_fill >= 10);
         e.tag_v = e.vld ? "R4" : "R6";
         e.tag_b = e.vld ? bit_tag : "R6";
         for (int k = 10; k >= 2; k--) m_h[k] = m_h[k-1];
         m_h[1] = b;
         if (m_fill < 10) m_fill++;
         m_last = y;
         e.chk = has_data && e.vld;
      end else begin
         e.vld = 1'b0;
         e.tag_v = "R5";
         e.tag_b = "R5";
      end
      e.b = m_last;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic raw(bit b);
      step(1'b1, b, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic reseed(bit [8:0] seed, bit t0);
      for (int k = 1; k <= 9; k++) e_s[k] = seed[k-1];
      e_t = t0;
      e_cnt = 0;
   endtask

   // scramble one data bit (divide by x^9+x^4+1), NRZI-encode, send
   task automatic send_data(bit d);
      bit s;
      s = d ^ e_s[4] ^ e_s[9];
      for (int k = 9; k >= 2; k--) e_s[k] = e_s[k-1];
      e_s[1] = s;
      e_t = e_t ^ s;
      e_cnt++;
      step(1'b1, e_t, 1'b0, (e_cnt > 10), d);
   endtask

   task automatic send_word(bit [9:0] w);
      for (int k = 0; k < 10; k++) send_data(w[k]);
   endtask

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tag_v, dec_valid, e.vld);
            check(e.tag_b, dec_bit, e.b);
            if (e.chk) check("R7", dec_bit, e.data);
            check("R8", alt_bit, dec_bit);
            check("R8", alt_valid, dec_valid);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R4 actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      bit [15:0] lfsr;
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      // R6: fill phase with gaps around the 10th/11th strobe
      for (int i = 0; i < 9; i++) raw(i[0] ^ i[2]);
      idle(2);
      raw(1'b1);
      idle(1);
      raw(1'b0);
      idle(3);
      raw(1'b1);
      // R2: constant level decodes to all-zero NRZ
      bit_tag = "R2";
      for (int i = 0; i < 20; i++) raw(1'b1);
      for (int i = 0; i < 20; i++) raw(1'b0);
      // R2: alternating level, NRZ all ones
      for (int i = 0; i < 20; i++) raw(i[0]);
      bit_tag = "R3";
      // R3: irregular raw patterns with idle gaps (R5)
      lfsr = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         raw(lfsr[0]);
         if (lfsr[3:1] == 3'b000) idle(int'(lfsr[5:4]) + 1);
      end
      // R1: reset together with a strobe, then refill
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 14; i++) raw(i[1]);
      // R7: scrambled random data, nonzero transmitter state
      reseed(9'h1A5, 1'b1);
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send_data(lfsr[0]);
         if (lfsr[7:5] == 3'b111) idle(1);
      end
      // R7: DC-heavy word pair and slip-prone word pair
      reseed(9'h0F3, 1'b0);
      for (int i = 0; i < 20; i++) begin
         send_word(10'h300);
         send_word(10'h198);
      end
      reseed(9'h155, 1'b1);
      for (int i = 0; i < 20; i++) begin
         send_word(10'h200);
         send_word(10'h110);
      end
      // R7: long zero data
      reseed(9'h1FF, 1'b0);
      for (int i = 0; i < 60; i++) send_data(1'b0);
      // R1: mid-run reset, then data again
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      reseed(9'h0AA, 1'b1);
      for (int i = 0; i < 80; i++) send_data(i[0] ^ i[3]);
      idle(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule